// File: doc/BRIEF.md
# DMA Channel Start and Chaining Controller

This block is the control logic for a single DMA channel. Software programs it through a small register write port. It then either moves one segment described by its own source, destination and count registers (direct mode), or walks a linked list of descriptors held in memory (chaining mode). In chaining mode each four-word descriptor is read through a simple memory read port before its segment runs. The data movement itself is handed to an external mover through a level request and a one-cycle done pulse.

A transfer can be started in several ways. Software can raise the start bit from 0 to 1. In direct mode it can instead write the source or the destination register alone. In chaining mode it can write the descriptor pointer alone. A 0-to-1 edge on the abort bit stops the channel at once. A two-bit state output lets software poll for idle before it programs the channel. A level interrupt reports completed segments.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `chan_state` is 0 (idle), `irq`, `xfer_req` and `mem_rd_req` are low, and the status register (address 1) reads 0. `chan_state` encodes idle=0, descriptor fetch=1, transfer=2, error=3.
- R2: Register map (word addresses): 0 mode, 1 status, 2 source, 3 destination, 4 count, 5 descriptor pointer. Mode bits: 0 direct, 1 start, 2 abort, 3 trigger select, 4 extended, 5 segment interrupt enable, 6 single-write enable. With mode bit 0 set, a write that takes the start bit from 0 to 1 puts the channel in state 2 on the write's clock edge. `xfer_req` is then held with the source, destination and count register values until `xfer_done`, after which the channel returns to 0.
- R3: With mode bits 0 and 6 set, a write to the source register (bit 3 = 1) or to the destination register (bit 3 = 0) starts a direct transfer and sets mode bit 1. A write to the other of the two registers does not start one.
- R4: With mode bits 0 and 4 both clear, a 0-to-1 start edge enters state 1. The channel then reads descriptor words at pointer, +4, +8 and +12, in the order source, destination, next pointer, count, and runs that segment. Writing 1 over a start bit that is already 1 starts nothing. With bit 4 set, chaining never starts.
- R5: With mode bits 0 and 4 clear and bit 3 set, a write to the descriptor pointer register starts a chain.
- R6: After a chained segment completes, if bit 0 of its next-pointer word is 0, the pointer register takes the next pointer and another fetch follows. If that bit is 1, the chain ends in state 0.
- R7: Status bit 0 (busy) reads 1 exactly while the channel is in state 1 or 2. `xfer_req` and `mem_rd_req` are never high together.
- R8: A mode write that takes the abort bit from 0 to 1 while busy returns the channel to state 0 on that edge. It drops `xfer_req` and `mem_rd_req` and sets no segment status.
- R9: An error on a descriptor read or from the mover puts the channel in state 3 and sets sticky status bit 2, with busy clear. Writing 1 to status bit 2 clears it and returns the channel to state 0.
- R10: A segment finishing without error, while mode bit 5 is set, sets status bit 1. `irq` follows that bit at level until software writes 1 to it. With bit 5 clear, neither is set.
- R11: Outside state 0, writes to the source, destination, count and pointer registers are ignored and start nothing, so their read-back values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_rd_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_rd_addr | output | ADDR_W | Descriptor word byte address |
| mem_rd_ack | input | 1 | Read acknowledge, one cycle |
| mem_rd_data | input | 32 | Read data, valid with acknowledge |
| mem_rd_err | input | 1 | Read error, valid with acknowledge |
| xfer_req | output | 1 | Segment request to data mover |
| xfer_src | output | ADDR_W | Segment source address |
| xfer_dst | output | ADDR_W | Segment destination address |
| xfer_cnt | output | CNT_W | Segment byte count |
| xfer_done | input | 1 | Segment finished, one cycle |
| xfer_err | input | 1 | Segment error, valid with done |
| chan_state | output | 2 | Channel state code |
| irq | output | 1 | Segment interrupt, level |

## Verification
A start, abort, error clear or ignored write takes effect on the same clock edge that captures the register write. The bench therefore samples `chan_state`, `xfer_req` and the status register at the falling edge right after that write. Each descriptor word takes one cycle once acknowledged, so the fetch address moves on by 4 at each falling edge while acknowledges are returned immediately. Segment values are compared by the mover model on the cycle it raises done. Completion status is read only after the state has been observed back at idle or error.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_XFER  = 2'd2,
      ST_ERROR = 2'd3
   } chan_state_e;

   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] RA_MODE = 3'd0;
   localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
   localparam logic [REG_AW-1:0] RA_SRC  = 3'd2;
   localparam logic [REG_AW-1:0] RA_DST  = 3'd3;
   localparam logic [REG_AW-1:0] RA_CNT  = 3'd4;
   localparam logic [REG_AW-1:0] RA_CDP  = 3'd5;

   // mode register bit positions
   localparam int MB_DIRECT = 0;
   localparam int MB_START  = 1;
   localparam int MB_ABORT  = 2;
   localparam int MB_SEL    = 3;
   localparam int MB_EXT    = 4;
   localparam int MB_EIE    = 5;
   localparam int MB_SWEN   = 6;
   localparam int MODE_W    = 7;

   // status register bit positions
   localparam int SB_BUSY = 0;
   localparam int SB_EOS  = 1;
   localparam int SB_ERR  = 2;

   // descriptor layout
   localparam int DESC_WORDS = 4;
   localparam int DW_SRC  = 0;
   localparam int DW_DST  = 1;
   localparam int DW_NEXT = 2;
   localparam int DW_CNT  = 3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_AW-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [REG_AW-1:0]   rd_addr,
   output logic [31:0]         rd_data,
   input  chan_state_e         state,
   input  logic                seg_ok,
   input  logic                err_set,
   input  logic                cdp_adv,
   input  logic [ADDR_W-1:0]   cdp_next,
   output logic [ADDR_W-1:0]   src_q,
   output logic [ADDR_W-1:0]   dst_q,
   output logic [CNT_W-1:0]    cnt_q,
   output logic [ADDR_W-1:0]   cdp_q,
   output logic                eos_q,
   output logic                err_q,
   output logic                start_evt,
   output logic                start_chain,
   output logic                abort_rise,
   output logic                err_clr
);
   logic [MODE_W-1:0] mode_q;
   logic [MODE_W-1:0] mode_new;
   logic [MODE_W-1:0] mode_eff;
   logic mode_wr, stat_wr, idle, busy;
   logic edge_start, chain_ok, sw_src, sw_dst, sw_cdp, trig;

   assign mode_new = wr_data[MODE_W-1:0];
   assign mode_wr  = wr_en && (wr_addr == RA_MODE);
   assign stat_wr  = wr_en && (wr_addr == RA_STAT);
   assign idle     = (state == ST_IDLE);
   assign busy     = (state == ST_FETCH) || (state == ST_XFER);

   always_comb begin
      mode_eff   = mode_wr ? mode_new : mode_q;
      abort_rise = mode_wr && mode_new[MB_ABORT] && !mode_q[MB_ABORT];
      edge_start = mode_wr && mode_new[MB_START] && !mode_q[MB_START];
      chain_ok   = !mode_eff[MB_DIRECT] && !mode_eff[MB_EXT];
      sw_src     = wr_en && (wr_addr == RA_SRC) && mode_q[MB_DIRECT]
                   && mode_q[MB_SWEN] && mode_q[MB_SEL];
      sw_dst     = wr_en && (wr_addr == RA_DST) && mode_q[MB_DIRECT]
                   && mode_q[MB_SWEN] && !mode_q[MB_SEL];
      sw_cdp     = wr_en && (wr_addr == RA_CDP) && !mode_q[MB_DIRECT]
                   && !mode_q[MB_EXT] && mode_q[MB_SEL];
      trig       = (edge_start && (mode_eff[MB_DIRECT] || chain_ok))
                   || sw_src || sw_dst || sw_cdp;
      start_evt  = idle && trig && !abort_rise;
      start_chain = !mode_eff[MB_DIRECT];
      err_clr    = stat_wr && wr_data[SB_ERR] && err_q;
   end

   // mode register: software value, start bit forced on a single-write start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_wr) begin
         mode_q <= mode_new;
      end else if (start_evt) begin
         mode_q[MB_START] <= 1'b1;
      end
   end

   // data registers accept writes only while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
         cdp_q <= '0;
      end else begin
         if (idle && wr_en && (wr_addr == RA_SRC)) src_q <= wr_data[ADDR_W-1:0];
         if (idle && wr_en && (wr_addr == RA_DST)) dst_q <= wr_data[ADDR_W-1:0];
         if (idle && wr_en && (wr_addr == RA_CNT)) cnt_q <= wr_data[CNT_W-1:0];
         if (cdp_adv) begin
            cdp_q <= cdp_next;
         end else if (idle && wr_en && (wr_addr == RA_CDP)) begin
            cdp_q <= wr_data[ADDR_W-1:0];
         end
      end
   end

   // sticky status bits, set has priority over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eos_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (seg_ok && mode_q[MB_EIE])         eos_q <= 1'b1;
         else if (stat_wr && wr_data[SB_EOS])  eos_q <= 1'b0;
         if (err_set)                          err_q <= 1'b1;
         else if (stat_wr && wr_data[SB_ERR])  err_q <= 1'b0;
      end
   end

   always_comb begin
      case (rd_addr)
         RA_MODE: rd_data = 32'(mode_q);
         RA_STAT: rd_data = 32'({err_q, eos_q, busy});
         RA_SRC:  rd_data = 32'(src_q);
         RA_DST:  rd_data = 32'(dst_q);
         RA_CNT:  rd_data = 32'(cnt_q);
         RA_CDP:  rd_data = 32'(cdp_q);
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dma_chan_fetch.sv
module dma_chan_fetch
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BYTE_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              kill,
   input  logic [ADDR_W-1:0] base,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [31:0]       rd_data,
   input  logic              rd_err,
   output logic              done,
   output logic              err,
   output logic [31:0]       d_src,
   output logic [31:0]       d_dst,
   output logic [31:0]       d_next,
   output logic [31:0]       d_cnt
);
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

   logic              active;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] offs;
   logic [31:0]       word_q [DESC_WORDS];
   logic              take;

   generate
      if (BYTE_ADDR != 0) begin : g_byte_step
         assign offs = ADDR_W'({idx, 2'b00});
      end else begin : g_word_step
         assign offs = ADDR_W'(idx);
      end
   endgenerate

   assign rd_req  = active;
   assign rd_addr = base + offs;
   assign take    = active && rd_ack;
   assign done    = take && !rd_err && (idx == IDX_LAST);
   assign err     = take && rd_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         for (int w = 0; w < DESC_WORDS; w++) word_q[w] <= '0;
      end else if (kill) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (go) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (take) begin
         if (rd_err || (idx == IDX_LAST)) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
         if (!rd_err) begin
            for (int w = 0; w < DESC_WORDS; w++) begin
               if (idx == IDX_W'(w)) word_q[w] <= rd_data;
            end
         end
      end
   end

   assign d_src  = word_q[DW_SRC];
   assign d_dst  = word_q[DW_DST];
   assign d_next = word_q[DW_NEXT];
   assign d_cnt  = word_q[DW_CNT];
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_chan_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_evt,
   input  logic        start_chain,
   input  logic        abort_rise,
   input  logic        err_clr,
   input  logic        fetch_done,
   input  logic        fetch_err,
   input  logic        xfer_done,
   input  logic        xfer_err,
   input  logic        last_desc,
   output chan_state_e state,
   output logic        chain_q,
   output logic        fetch_go,
   output logic        fetch_kill,
   output logic        seg_ok,
   output logic        err_set,
   output logic        cdp_adv
);
   chan_state_e nxt;

   always_comb begin
      nxt        = state;
      fetch_go   = 1'b0;
      fetch_kill = 1'b0;
      seg_ok     = 1'b0;
      err_set    = 1'b0;
      cdp_adv    = 1'b0;
      case (state)
         ST_IDLE: begin
            if (start_evt) begin
               if (start_chain) begin
                  nxt      = ST_FETCH;
                  fetch_go = 1'b1;
               end else begin
                  nxt = ST_XFER;
               end
            end
         end
         ST_FETCH: begin
            if (abort_rise) begin
               nxt        = ST_IDLE;
               fetch_kill = 1'b1;
            end else if (fetch_err) begin
               nxt     = ST_ERROR;
               err_set = 1'b1;
            end else if (fetch_done) begin
               nxt = ST_XFER;
            end
         end
         ST_XFER: begin
            if (abort_rise) begin
               nxt = ST_IDLE;
            end else if (xfer_done) begin
               if (xfer_err) begin
                  nxt     = ST_ERROR;
                  err_set = 1'b1;
               end else begin
                  seg_ok = 1'b1;
                  if (chain_q && !last_desc) begin
                     nxt      = ST_FETCH;
                     fetch_go = 1'b1;
                     cdp_adv  = 1'b1;
                  end else begin
                     nxt = ST_IDLE;
                  end
               end
            end
         end
         ST_ERROR: begin
            if (err_clr) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         chain_q <= 1'b0;
      end else begin
         state <= nxt;
         if (start_evt && (state == ST_IDLE)) chain_q <= start_chain;
      end
   end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 24,
   parameter int BYTE_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_wr_addr,
   input  logic [31:0]       reg_wr_data,
   input  logic [2:0]        reg_rd_addr,
   output logic [31:0]       reg_rd_data,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [31:0]       mem_rd_data,
   input  logic              mem_rd_err,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] xfer_src,
   output logic [ADDR_W-1:0] xfer_dst,
   output logic [CNT_W-1:0]  xfer_cnt,
   input  logic              xfer_done,
   input  logic              xfer_err,
   output logic [1:0]        chan_state,
   output logic              irq
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("dma_chan_ctrl: ADDR_W must lie in 8..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("dma_chan_ctrl: CNT_W must lie in 1..32");
      end
      if (BYTE_ADDR != 0 && BYTE_ADDR != 1) begin : g_bad_byte
         $error("dma_chan_ctrl: BYTE_ADDR must be 0 or 1");
      end
   endgenerate

   chan_state_e       state;
   logic [ADDR_W-1:0] src_q, dst_q, cdp_q, cdp_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              eos_q, err_q;
   logic              start_evt, start_chain, abort_rise, err_clr;
   logic              chain_q, fetch_go, fetch_kill, seg_ok, err_set, cdp_adv;
   logic              fetch_done, fetch_err;
   logic [31:0]       d_src, d_dst, d_next, d_cnt;
   logic              unused_desc_bits;

   dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .state(state), .seg_ok(seg_ok), .err_set(err_set),
      .cdp_adv(cdp_adv), .cdp_next(cdp_next),
      .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cdp_q(cdp_q),
      .eos_q(eos_q), .err_q(err_q),
      .start_evt(start_evt), .start_chain(start_chain),
      .abort_rise(abort_rise), .err_clr(err_clr)
   );

   dma_chan_fetch #(.ADDR_W(ADDR_W), .BYTE_ADDR(BYTE_ADDR)) i_fetch (
      .clk(clk), .rst_n(rst_n),
      .go(fetch_go), .kill(fetch_kill), .base(cdp_next_or_cur()),
      .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
      .rd_ack(mem_rd_ack), .rd_data(mem_rd_data), .rd_err(mem_rd_err),
      .done(fetch_done), .err(fetch_err),
      .d_src(d_src), .d_dst(d_dst), .d_next(d_next), .d_cnt(d_cnt)
   );

   dma_chan_seq i_seq (
      .clk(clk), .rst_n(rst_n),
      .start_evt(start_evt), .start_chain(start_chain),
      .abort_rise(abort_rise), .err_clr(err_clr),
      .fetch_done(fetch_done), .fetch_err(fetch_err),
      .xfer_done(xfer_done), .xfer_err(xfer_err),
      .last_desc(d_next[0]),
      .state(state), .chain_q(chain_q),
      .fetch_go(fetch_go), .fetch_kill(fetch_kill),
      .seg_ok(seg_ok), .err_set(err_set), .cdp_adv(cdp_adv)
   );

   // the fetch address always follows the live pointer register
   function automatic logic [ADDR_W-1:0] cdp_next_or_cur();
      return cdp_q;
   endfunction

   assign cdp_next = {d_next[ADDR_W-1:1], 1'b0};

   assign xfer_req   = (state == ST_XFER);
   assign xfer_src   = chain_q ? d_src[ADDR_W-1:0] : src_q;
   assign xfer_dst   = chain_q ? d_dst[ADDR_W-1:0] : dst_q;
   assign xfer_cnt   = chain_q ? d_cnt[CNT_W-1:0]  : cnt_q;
   assign chan_state = state;
   assign irq        = eos_q;

   assign unused_desc_bits = ^{d_src, d_dst, d_next, d_cnt};
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        chan_state,
   input logic              xfer_req,
   input logic              xfer_done,
   input logic              mem_rd_req,
   input logic              mem_rd_ack,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              abort_rise,
   input logic              err_flag,
   input logic              irq
);
   assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_req && mem_rd_req));

   assert_xfer_in_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (chan_state == 2'd2));

   assert_fetch_in_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (chan_state == 2'd1));

   assert_fetch_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack && !abort_rise) |=> $stable(mem_rd_addr));

   assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((chan_state == 2'd1 || chan_state == 2'd2) && abort_rise) |=> (chan_state == 2'd0));

   assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_state == 2'd3) |-> err_flag);

   assert_error_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_state == 2'd3) |=> (chan_state == 2'd3 || chan_state == 2'd0));

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(chan_state == 2'd2 && xfer_done));
endmodule

bind dma_chan_ctrl dma_chan_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .chan_state(chan_state),
   .xfer_req(xfer_req), .xfer_done(xfer_done),
   .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_rd_addr(mem_rd_addr),
   .abort_rise(abort_rise), .err_flag(err_q), .irq(irq)
);

// File: tb/test_dma_chan_ctrl.sv
`timescale 1ns/1ps
module test_dma_chan_ctrl;
   localparam int AW = 32;
   localparam int CW = 24;
   localparam logic [2:0] A_MODE = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2,
                          A_DST = 3'd3, A_CNT = 3'd4, A_CDP = 3'd5;
   localparam logic [31:0] M_DIRECT = 32'h01, M_START = 32'h02, M_ABORT = 32'h04,
                           M_SEL = 32'h08, M_EXT = 32'h10, M_EIE = 32'h20, M_SWEN = 32'h40;

   logic clk, rst_n;
   logic reg_wr_en;
   logic [2:0] reg_wr_addr, reg_rd_addr;
   logic [31:0] reg_wr_data, reg_rd_data;
   logic mem_rd_req, mem_rd_ack, mem_rd_err;
   logic [AW-1:0] mem_rd_addr;
   logic [31:0] mem_rd_data;
   logic xfer_req, xfer_done, xfer_err;
   logic [AW-1:0] xfer_src, xfer_dst;
   logic [CW-1:0] xfer_cnt;
   logic [1:0] chan_state;
   logic irq;

   dma_chan_ctrl #(.ADDR_W(AW), .CNT_W(CW)) i_dma_chan_ctrl (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
      .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
      .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_cnt(xfer_cnt),
      .xfer_done(xfer_done), .xfer_err(xfer_err),
      .chan_state(chan_state), .irq(irq)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   typedef struct {
      logic [31:0] s;
      logic [31:0] d;
      logic [31:0] c;
   } seg_t;
   seg_t exp_q[$];

   int n_total = 0;
   int n_bad = 0;
   int mover_lat = 2;
   logic mover_err = 1'b0;
   logic [31:0] mem [0:63];
   logic [31:0] err_addr = 32'hFFFF_FFFF;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_test();
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_rd_addr = a;
      #1;
      d = reg_rd_data;
   endtask

   task automatic push_exp(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      seg_t e;
      e.s = s; e.d = d; e.c = c;
      exp_q.push_back(e);
   endtask

   task automatic wait_leave(input logic [1:0] st);
      for (int i = 0; i < 500 && chan_state == st; i++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500 && chan_state != 2'd0; i++) @(negedge clk);
   endtask

   // memory model: acknowledges every request at the following falling edge
   initial begin
      mem_rd_ack = 1'b0; mem_rd_data = '0; mem_rd_err = 1'b0;
      forever begin
         @(negedge clk);
         mem_rd_ack  = mem_rd_req;
         mem_rd_data = mem[mem_rd_addr[7:2]];
         mem_rd_err  = mem_rd_req && (mem_rd_addr == err_addr);
      end
   end

   // data mover model and scoreboard monitor
   initial begin
      seg_t e;
      int wc;
      wc = 0;
      xfer_done = 1'b0; xfer_err = 1'b0;
      forever begin
         @(negedge clk);
         if (xfer_done) begin
            xfer_done = 1'b0; xfer_err = 1'b0; wc = 0;
         end else if (xfer_req) begin
            wc++;
            if (wc >= mover_lat) begin
               if (exp_q.size() == 0) begin
                  n_total++; n_bad++;
                  $display("FAIL R2: unexpected segment actual=%h expected=none", xfer_src);
               end else begin
                  e = exp_q.pop_front();
                  check("R2 segment source", xfer_src, e.s);
                  check("R2 segment destination", xfer_dst, e.d);
                  check("R2 segment count", 32'(xfer_cnt), e.c);
               end
               xfer_done = 1'b1; xfer_err = mover_err;
            end
         end else begin
            wc = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_total++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_test();
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
      // descriptor A at 0x40, B at 0x80 (last)
      mem[16] = 32'h100; mem[17] = 32'h200; mem[18] = 32'h80; mem[19] = 32'h10;
      mem[32] = 32'h300; mem[33] = 32'h400; mem[34] = 32'h1;  mem[35] = 32'h20;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 state", 32'(chan_state), 0);
      check("R1 irq", 32'(irq), 0);
      check("R1 xfer_req", 32'(xfer_req), 0);
      check("R1 mem_rd_req", 32'(mem_rd_req), 0);
      rd(A_STAT, v); check("R1 status", v, 0);

      // R2 direct start by start edge, R10 interrupt
      wr(A_SRC, 32'h1000); wr(A_DST, 32'h2000); wr(A_CNT, 32'd64);
      push_exp(32'h1000, 32'h2000, 32'd64);
      wr(A_MODE, M_DIRECT | M_START | M_EIE);
      check("R2 state transfer", 32'(chan_state), 2);
      rd(A_STAT, v); check("R7 busy during transfer", v & 1, 1);
      wait_idle();
      rd(A_STAT, v); check("R10 segment status", v, 32'h2);
      check("R10 irq level", 32'(irq), 1);
      @(negedge clk);
      check("R10 irq held", 32'(irq), 1);
      wr(A_STAT, 32'h2);
      check("R10 irq cleared", 32'(irq), 0);

      // R4 start written 1 over 1: no start
      wr(A_MODE, M_DIRECT | M_START | M_EIE);
      check("R4 no edge no start", 32'(chan_state), 0);

      // R10 no segment status with interrupt enable clear
      wr(A_MODE, M_DIRECT);
      push_exp(32'h1000, 32'h2000, 32'd64);
      wr(A_MODE, M_DIRECT | M_START);
      wait_idle();
      rd(A_STAT, v); check("R10 no status when disabled", v, 0);
      check("R10 no irq when disabled", 32'(irq), 0);

      // R3 single-write start, select = source
      wr(A_MODE, M_DIRECT | M_SWEN | M_SEL);
      wr(A_DST, 32'h3000);
      check("R3 destination write no start", 32'(chan_state), 0);
      push_exp(32'h5000, 32'h3000, 32'd64);
      wr(A_SRC, 32'h5000);
      check("R3 source write starts", 32'(chan_state), 2);
      rd(A_MODE, v); check("R3 start bit auto set", v & M_START, M_START);
      wait_idle();

      // R3 select = destination
      wr(A_MODE, M_DIRECT | M_SWEN);
      wr(A_SRC, 32'h6000);
      check("R3 source write no start", 32'(chan_state), 0);
      push_exp(32'h6000, 32'h7000, 32'd64);
      wr(A_DST, 32'h7000);
      check("R3 destination write starts", 32'(chan_state), 2);
      wait_idle();

      // R11 writes while busy ignored
      mover_lat = 20;
      wr(A_MODE, M_DIRECT | M_SWEN | M_SEL);
      push_exp(32'hA000, 32'h7000, 32'd64);
      wr(A_SRC, 32'hA000);
      wr(A_DST, 32'hBEEF0);
      wr(A_CNT, 32'd5);
      wr(A_SRC, 32'hC000);
      wait_idle();
      rd(A_DST, v); check("R11 destination unchanged", v, 32'h7000);
      rd(A_CNT, v); check("R11 count unchanged", v, 32'd64);
      rd(A_SRC, v); check("R11 source unchanged", v, 32'hA000);
      @(negedge clk);
      check("R11 no extra start", 32'(chan_state), 0);

      // R8 abort during transfer
      mover_lat = 50;
      wr(A_MODE, M_DIRECT | M_EIE);
      wr(A_MODE, M_DIRECT | M_START | M_EIE);
      repeat (3) @(negedge clk);
      wr(A_MODE, M_DIRECT | M_START | M_EIE | M_ABORT);
      check("R8 state idle after abort", 32'(chan_state), 0);
      check("R8 request dropped", 32'(xfer_req), 0);
      rd(A_STAT, v); check("R8 status after abort", v, 0);
      wr(A_MODE, M_DIRECT);
      mover_lat = 2;

      // R4 R6 chain by start edge
      wr(A_CDP, 32'h40);
      check("R4 pointer write in direct mode no start", 32'(chan_state), 0);
      push_exp(32'h100, 32'h200, 32'h10);
      push_exp(32'h300, 32'h400, 32'h20);
      wr(A_MODE, M_START | M_EIE);
      check("R4 fetch state", 32'(chan_state), 1);
      check("R4 fetch request", 32'(mem_rd_req), 1);
      check("R4 first word address", mem_rd_addr, 32'h40);
      @(negedge clk);
      check("R4 second word address", mem_rd_addr, 32'h44);
      wait_idle();
      rd(A_CDP, v); check("R6 pointer advanced", v, 32'h80);
      rd(A_STAT, v); check("R10 chain segment status", v, 32'h2);
      wr(A_STAT, 32'h2);

      // R4 extended bit blocks chaining
      wr(A_MODE, M_EXT);
      wr(A_MODE, M_EXT | M_START);
      check("R4 extended no start", 32'(chan_state), 0);
      check("R4 extended no fetch", 32'(mem_rd_req), 0);

      // R5 chain by pointer write
      wr(A_MODE, M_SEL);
      push_exp(32'h300, 32'h400, 32'h20);
      wr(A_CDP, 32'h80);
      check("R5 pointer write starts chain", 32'(chan_state), 1);
      wait_idle();

      // R9 descriptor read error
      err_addr = 32'h88;
      wr(A_CDP, 32'h80);
      wait_leave(2'd1);
      check("R9 error state on read error", 32'(chan_state), 3);
      rd(A_STAT, v); check("R9 sticky error, busy clear", v & 32'h5, 32'h4);
      wr(A_CDP, 32'h40);
      check("R11 no start in error", 32'(chan_state), 3);
      rd(A_CDP, v); check("R11 pointer unchanged in error", v, 32'h80);
      wr(A_STAT, 32'h4);
      check("R9 clear returns idle", 32'(chan_state), 0);
      err_addr = 32'hFFFF_FFFF;

      // R9 mover error
      wr(A_MODE, M_DIRECT);
      mover_err = 1'b1;
      push_exp(32'hA000, 32'h7000, 32'd64);
      wr(A_MODE, M_DIRECT | M_START);
      wait_leave(2'd2);
      check("R9 error state on mover error", 32'(chan_state), 3);
      rd(A_STAT, v); check("R9 error bit from mover", v, 32'h4);
      mover_err = 1'b0;
      wr(A_STAT, 32'h4);
      check("R9 mover error cleared", 32'(chan_state), 0);

      check("R6 all segments seen", exp_q.size(), 0);
      repeat (2) @(negedge clk);
      finish_test();
   end
endmodule